// File: doc/BRIEF.md
# Buffered GCD Coprocessor

This block computes the greatest common divisor of two unsigned W-bit numbers. Operand pairs come in over a valid/ready handshake and land in a small request queue. A single iterative engine takes the oldest pair from that queue and runs a subtract-and-swap loop under a three-state controller. It places each finished result in a response queue, which drains over a second valid/ready handshake.

The two queues decouple the engine from both handshakes. A producer can therefore post several pairs before the first answer is collected, and a slow consumer does not stall the producer until both queues fill. Results always leave in the order their operands were accepted. The engine holds off a new computation while the response queue has no free slot, so no result is ever discarded.

Top module: `gcd_buffered`

## Requirements
- R1: Each result equals the greatest common divisor of its unsigned operand pair. A zero operand yields the other operand, so gcd(x,0) = gcd(0,x) = x, and gcd(0,0) = 0. Every pair finishes.
- R2: Results appear on the output in the same order as their operand pairs were accepted, one result per accepted pair.
- R3: A pair is accepted on a rising edge where inValid and inReady are both high. A result is consumed on a rising edge where outValid and outReady are both high. While outValid is high and outReady is low, outValid stays high and outGcd keeps its value.
- R4: With each queue DEPTH entries deep (default 4) and outReady held low, the block accepts exactly 2*DEPTH pairs and then holds inReady low. DEPTH results are parked in the response queue and DEPTH pairs wait in the request queue. None of these pairs is lost when the output later drains.
- R5: A synchronous active-high reset empties both queues and returns the engine to idle. After reset, inReady is high and outValid is low, and no result from before the reset ever appears.
- R6: The default data width is 32. The width parameter W sets the width of both operands, the result and every internal data path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operand pair on inA/inB is offered |
| inReady | output | 1 | Request queue has a free slot |
| inA | input | W | First operand |
| inB | input | W | Second operand |
| outValid | output | 1 | outGcd holds the oldest finished result |
| outReady | input | 1 | Consumer takes the result this cycle |
| outGcd | output | W | Greatest common divisor |

## Verification
Three events can fall on the same clock edge: a new pair enters the request queue, the engine retires a pair while pushing its result, and the consumer pops a result. This is most telling when a queue is at one end of its range. The bench provokes these coincidences by running an exhaustive sweep of all 1024 operand pairs for a 5-bit width, with inValid and outReady gated by different periodic patterns, and by repeating part of the sweep at full rate on both sides. Each popped result is judged against a Euclid remainder loop in the bench, in acceptance order. A stalled-output phase and a mid-stream reset confirm the capacity and discard behaviour.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_DONE = 2'd2
  } gcd_state_t;

  // strobes from controller to datapath
  typedef struct packed {
    logic load;
    logic swap;
    logic sub;
  } gcd_strobe_t;

endpackage

// File: rtl/gcd_queue.sv
module gcd_queue #(
  parameter int DW    = 64,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enqValid,
  output logic          enqReady,
  input  logic [DW-1:0] enqData,
  output logic          deqValid,
  input  logic          deqReady,
  output logic [DW-1:0] deqData
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] slots [DEPTH];
  logic [AW-1:0] wPtr, rPtr;
  logic          isFull;
  logic          isEmpty;
  logic          doEnq, doDeq;

  assign isEmpty  = (wPtr == rPtr) && !isFull;
  assign enqReady = !isFull;
  assign deqValid = !isEmpty;
  assign deqData  = slots[rPtr];
  assign doEnq    = enqValid && !isFull;
  assign doDeq    = deqReady && !isEmpty;

  always_ff @(posedge clk) begin
    if (doEnq) slots[wPtr] <= enqData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wPtr   <= '0;
      rPtr   <= '0;
      isFull <= 1'b0;
    end else begin
      if (doEnq) wPtr <= wPtr + AW'(1);
      if (doDeq) rPtr <= rPtr + AW'(1);
      if (doEnq && !doDeq && ((wPtr + AW'(1)) == rPtr))
        isFull <= 1'b1;
      else if (doDeq && !doEnq)
        isFull <= 1'b0;
    end
  end

  // R3: head entry held while not taken
  a_r3_head_hold: assert property (@(posedge clk) disable iff (rst)
    (deqValid && !deqReady) |=> (deqValid && $stable(deqData)));

  // R5: queue comes out of reset empty with space
  a_r5_reset_empty: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!deqValid && enqReady));

endmodule

// File: rtl/gcd_engine_dp.sv
module gcd_engine_dp
  import gcd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  gcd_strobe_t strb,
  input  logic [W-1:0] loadA,
  input  logic [W-1:0] loadB,
  output logic        bZero,
  output logic        aLtB,
  output logic [W-1:0] result
);
  logic [W-1:0] regA, regB;

  always_ff @(posedge clk) begin
    if (strb.load) begin
      regA <= loadA;
      regB <= loadB;
    end else if (strb.swap) begin
      regA <= regB;
      regB <= regA;
    end else if (strb.sub) begin
      regA <= regA - regB;
    end
  end

  assign bZero  = (regB == '0);
  assign aLtB   = (regA < regB);
  assign result = regA;

  // R1: swap exchanges the operands
  a_r1_swap: assert property (@(posedge clk) disable iff (rst)
    (strb.swap && !strb.load) |=> (regA == $past(regB) && regB == $past(regA)));

  // R1: subtraction never underflows
  a_r1_sub_order: assert property (@(posedge clk) disable iff (rst)
    (strb.sub && !strb.load && !strb.swap) |-> !aLtB);

endmodule

// File: rtl/gcd_engine_ctl.sv
module gcd_engine_ctl
  import gcd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        respSpace,
  input  logic        bZero,
  input  logic        aLtB,
  output gcd_strobe_t strb,
  output logic        reqPop,
  output logic        respPush
);
  gcd_state_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    reqPop    = 1'b0;
    respPush  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid && respSpace) begin
          strb.load = 1'b1;
          stateNext = ST_CALC;
        end
      end
      ST_CALC: begin
        if (bZero)     stateNext = ST_DONE;
        else if (aLtB) strb.swap = 1'b1;
        else           strb.sub  = 1'b1;
      end
      ST_DONE: begin
        respPush  = 1'b1;
        reqPop    = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  // R4: a finished result always finds a free slot
  a_r4_no_drop: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |-> respSpace);

  // R1: a zero second operand ends the loop
  a_r1_finish: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CALC && bZero) |=> (state == ST_DONE));

  // R2: the request is retired only together with its result
  a_r2_pop_pair: assert property (@(posedge clk) disable iff (rst)
    reqPop |-> (respPush && reqValid));

endmodule

// File: rtl/gcd_buffered.sv
module gcd_buffered #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output logic         inReady,
  input  logic [W-1:0] inA,
  input  logic [W-1:0] inB,
  output logic         outValid,
  input  logic         outReady,
  output logic [W-1:0] outGcd
);
  import gcd_pkg::*;

  localparam int REQ_W = 2 * W;

  logic [REQ_W-1:0] reqHead;
  logic             reqValid, reqPop;
  logic             respSpace, respPush;
  logic             bZero, aLtB;
  logic [W-1:0]     engResult;
  gcd_strobe_t      strb;

  gcd_queue #(.DW(REQ_W), .DEPTH(DEPTH)) u_reqQ (
    .clk(clk), .rst(rst),
    .enqValid(inValid), .enqReady(inReady), .enqData({inA, inB}),
    .deqValid(reqValid), .deqReady(reqPop), .deqData(reqHead)
  );

  gcd_engine_ctl u_ctl (
    .clk(clk), .rst(rst),
    .reqValid(reqValid), .respSpace(respSpace),
    .bZero(bZero), .aLtB(aLtB),
    .strb(strb), .reqPop(reqPop), .respPush(respPush)
  );

  gcd_engine_dp #(.W(W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .loadA(reqHead[REQ_W-1:W]), .loadB(reqHead[W-1:0]),
    .bZero(bZero), .aLtB(aLtB), .result(engResult)
  );

  gcd_queue #(.DW(W), .DEPTH(DEPTH)) u_respQ (
    .clk(clk), .rst(rst),
    .enqValid(respPush), .enqReady(respSpace), .enqData(engResult),
    .deqValid(outValid), .deqReady(outReady), .deqData(outGcd)
  );

  // R3: an offered result is not withdrawn
  a_r3_out_hold: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> outValid);

endmodule

// File: tb/gcd_buffered_tb.sv
`timescale 1ns/1ps
module gcd_buffered_tb;
  localparam int W = 5;
  localparam int N = 1 << (2 * W);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [W-1:0] inA = '0;
  logic [W-1:0] inB = '0;
  logic         outValid;
  logic         outReady = 1'b0;
  logic [W-1:0] outGcd;

  int pa [N];
  int pb [N];
  int sent, got;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  gcd_buffered #(.W(W), .DEPTH(4)) u_dut (
    .clk(clk), .rst(rst),
    .inValid(inValid), .inReady(inReady), .inA(inA), .inB(inB),
    .outValid(outValid), .outReady(outReady), .outGcd(outGcd)
  );

  function automatic int refGcd(int a, int b);
    int x = a, y = b, t;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // streams pairs pa/pb[sent..n-1] in and checks results got..n-1
  task automatic stream(int n, int rdyMod, int valMod, int limit);
    int cyc = 0;
    while (got < n && cyc < limit) begin
      @(negedge clk);
      cyc++;
      inValid  = (sent < n) && (valMod == 0 || (cyc % valMod) != 0);
      outReady = (rdyMod == 0) || (cyc % rdyMod) != 0;
      inA = W'(pa[sent < n ? sent : 0]);
      inB = W'(pb[sent < n ? sent : 0]);
      #1;
      if (inValid && inReady) sent++;
      if (outValid && outReady) begin
        // R1 value, R2 order
        check(int'(outGcd) == refGcd(pa[got], pb[got]), "R1/R2",
              int'(outGcd), refGcd(pa[got], pb[got]));
        got++;
      end
    end
    check(got == n, "R2 result count", got, n);
    @(negedge clk);
    inValid  = 1'b0;
    outReady = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int held;
    bit holdOk;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R5 reset state
    check(inReady == 1'b1, "R5 inReady after reset", int'(inReady), 1);
    check(outValid == 1'b0, "R5 outValid after reset", int'(outValid), 0);
    // R6: port width follows W
    check($bits(outGcd) == W, "R6 result width", $bits(outGcd), W);

    // R4: stalled output, capacity 2*DEPTH
    for (int i = 0; i < 12; i++) begin
      pa[i] = (i * 7 + 3) % 32;
      pb[i] = (i * 5 + 12) % 32;
    end
    sent = 0; got = 0;
    held = -1; holdOk = 1'b1;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      inValid  = (sent < 12);
      outReady = 1'b0;
      inA = W'(pa[sent < 12 ? sent : 0]);
      inB = W'(pb[sent < 12 ? sent : 0]);
      #1;
      if (inValid && inReady) sent++;
      if (outValid) begin
        if (held < 0) held = int'(outGcd);
        else if (int'(outGcd) != held) holdOk = 1'b0;
      end
    end
    check(sent == 8, "R4 accepted while stalled", sent, 8);
    check(inReady == 1'b0, "R4 inReady low when full", int'(inReady), 0);
    check(outValid == 1'b1, "R3 outValid held", int'(outValid), 1);
    check(holdOk, "R3 outGcd stable while stalled", int'(outGcd), held);
    stream(12, 0, 0, 4000);

    // R1/R2 exhaustive sweep with mixed handshake gaps
    for (int i = 0; i < N; i++) begin
      pa[i] = i >> W;
      pb[i] = i % (1 << W);
    end
    sent = 0; got = 0;
    stream(N, 3, 5, 120000);

    // full-rate on both sides, reversed order
    for (int i = 0; i < 256; i++) begin
      pa[i] = (N - 1 - i) % (1 << W);
      pb[i] = ((N - 1 - i) >> W) % (1 << W);
    end
    sent = 0; got = 0;
    stream(256, 0, 0, 30000);

    // zero corner cases, R1
    pa[0] = 0;  pb[0] = 0;
    pa[1] = 19; pb[1] = 0;
    pa[2] = 0;  pb[2] = 31;
    pa[3] = 31; pb[3] = 31;
    sent = 0; got = 0;
    stream(4, 2, 0, 2000);

    // R5 reset mid-stream discards pending work
    for (int i = 0; i < 3; i++) begin
      pa[i] = 30 - i; pb[i] = 6 + i;
    end
    sent = 0;
    while (sent < 3) begin
      @(negedge clk);
      inValid = 1'b1;
      inA = W'(pa[sent]); inB = W'(pb[sent]);
      #1;
      if (inReady) sent++;
    end
    @(negedge clk);
    inValid = 1'b0;
    repeat (60) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    check(outValid == 1'b0, "R5 outValid cleared", int'(outValid), 0);
    check(inReady == 1'b1, "R5 inReady restored", int'(inReady), 1);
    outReady = 1'b1;
    held = 0;
    repeat (80) begin
      @(negedge clk);
      #1;
      if (outValid) held++;
    end
    outReady = 1'b0;
    check(held == 0, "R5 no stale result", held, 0);

    pa[0] = 12; pb[0] = 18;
    pa[1] = 25; pb[1] = 10;
    sent = 0; got = 0;
    stream(2, 0, 0, 500);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule